// File: doc/BRIEF.md
# GPIO Pin Interrupt Controller with Trigger Modes

This block watches a bank of already synchronised input pins and turns their activity into pending flags and a single interrupt line. Out of reset every pin latches a pending flag whenever its level changes in either direction. Each pin may be switched, one at a time or in groups, into an extended mode. In that mode it triggers on one selected edge or on one selected level. The polarity and the edge-or-level choice are each held in a bit that has a separate write address for each value.

Software works through a small register port. The enable mask, the extended-mode enable, the trigger type and the polarity each have write-one addresses that set or clear the bits named in the written word, and each has a readable status view. Reading the pending register returns the flags and acknowledges them. A level condition that still holds raises its flag again at once. The interrupt output is high while any pending pin is also enabled in the mask. Pending flags are latched whether or not the pin is enabled in the mask.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the mask, extended-mode, type and polarity views all read 0 (every pin masked, both-edge detection, type edge, polarity falling/low), nothing is pending and `irq_o` is 0.
- R2: A write to address 0 sets the mask bits that are 1 in the data. A write to address 1 clears them. Address 2 reads the mask. Writing all ones to address 1 masks every pin.
- R3: A pin whose extended-mode bit is 0 sets its pending bit in the cycle after its input differs from the value it had one cycle earlier, for rising and falling changes alike.
- R4: A write to address 3 sets extended-mode bits and a write to address 4 clears them. Address 5 reads them. Clearing a bit returns that pin to both-edge detection.
- R5: A write to address 6 selects edge type and a write to address 7 selects level type for the pins named in the data. Address 8 reads the type, with 1 meaning level.
- R6: A write to address 9 selects falling/low polarity and a write to address 10 selects rising/high polarity. Address 11 reads the polarity, with 1 meaning rising/high.
- R7: In extended edge mode a pin flags only the 0-to-1 change when its polarity is 1, and only the 1-to-0 change when its polarity is 0.
- R8: In extended level mode a pin flags every cycle in which its input equals its polarity bit, so the flag survives a read for as long as the level holds.
- R9: Reading address 12 returns the pending bits in the same cycle and clears them at the next edge. An event detected in the same cycle as that read stays pending.
- R10: `irq_o` is the OR over all pins of pending AND mask, taken from registered state. Pending bits latch regardless of the mask.
- R11: Writes to addresses 2, 5, 8, 11, 12 or any unlisted address change nothing. `rdata_o` is 0 when no read is strobed, and a read of a write-only or unlisted address also returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | N_PINS | Synchronised pin levels |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | N_PINS | Write data, one bit per pin |
| rdata_o | output | N_PINS | Read data, valid in the cycle of `rd_i` |
| irq_o | output | 1 | Interrupt request |

## Verification
A write changes a configuration bit at the next clock edge, so it governs detection from the following cycle onward. A pin change seen in cycle k shows in the pending register and on `irq_o` in cycle k+1. Read data is combinational and due in the same cycle as the strobe, and the clearing effect of a status read appears one cycle later. The bench drives inputs just after the falling edge and compares every output against its own per-pin model one nanosecond before each rising edge, then advances the model with the same inputs the design sees at that edge.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   localparam int ADDR_W = 4;

   // register addresses of the bank
   typedef enum logic [ADDR_W-1:0] {
      A_MASK_SET  = 4'd0,
      A_MASK_CLR  = 4'd1,
      A_MASK_STAT = 4'd2,
      A_XM_SET    = 4'd3,
      A_XM_CLR    = 4'd4,
      A_XM_STAT   = 4'd5,
      A_TYP_EDGE  = 4'd6,
      A_TYP_LEVEL = 4'd7,
      A_TYP_STAT  = 4'd8,
      A_POL_LOW   = 4'd9,
      A_POL_HIGH  = 4'd10,
      A_POL_STAT  = 4'd11,
      A_PEND      = 4'd12
   } reg_addr_e;

endpackage

// File: rtl/gpio_irq_setclr.sv
module gpio_irq_setclr #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_i,
   input  logic         clr_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] q_o
);

   logic [W-1:0] q_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q_q <= '0;
      else if (set_i)
         q_q <= q_q | wdata_i;
      else if (clr_i)
         q_q <= q_q & ~wdata_i;
   end

   assign q_o = q_q;

   // R2 R4 R5 R6
   setbits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> ((q_o & $past(wdata_i)) == $past(wdata_i)));

   // R2 R4 R5 R6
   clrbits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> ((q_o & $past(wdata_i)) == '0));

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
   parameter int N_PINS    = 32,
   parameter bit EXT_MODES = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_PINS-1:0] pin_i,
   input  logic [N_PINS-1:0] xmode_i,
   input  logic [N_PINS-1:0] level_i,
   input  logic [N_PINS-1:0] high_i,
   output logic [N_PINS-1:0] evt_o
);

   // previous sample; valid after one clock in reset
   logic [N_PINS-1:0] prev_q;

   always_ff @(posedge clk) begin
      prev_q <= pin_i;
   end

   for (genvar g = 0; g < N_PINS; g++) begin : g_pin
      logic rise;
      logic fall;

      assign rise = pin_i[g] & ~prev_q[g];
      assign fall = ~pin_i[g] & prev_q[g];

      if (EXT_MODES) begin : g_ext
         logic lvl_hit;
         logic edge_hit;

         assign lvl_hit  = (pin_i[g] == high_i[g]);
         assign edge_hit = high_i[g] ? rise : fall;
         assign evt_o[g] = !xmode_i[g] ? (rise | fall)
                                       : (level_i[g] ? lvl_hit : edge_hit);

         // R7
         rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (xmode_i[g] && !level_i[g] && high_i[g] && $fell(pin_i[g])) |-> !evt_o[g]);
      end else begin : g_plain
         assign evt_o[g] = rise | fall;
      end

      // R3
      quiet_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!xmode_i[g] && $stable(pin_i[g])) |-> !evt_o[g]);
   end

endmodule

// File: rtl/gpio_irq_pend.sv
module gpio_irq_pend #(
   parameter int N_PINS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_PINS-1:0] evt_i,
   input  logic              ack_i,
   input  logic [N_PINS-1:0] mask_i,
   output logic [N_PINS-1:0] pend_o,
   output logic              irq_o
);

   logic [N_PINS-1:0] pend_q;

   // a fresh event wins over the acknowledge of the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend_q <= '0;
      else
         pend_q <= (pend_q & ~{N_PINS{ack_i}}) | evt_i;
   end

   assign pend_o = pend_q;
   assign irq_o  = |(pend_q & mask_i);

   // R9
   keep_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_i |=> ((pend_o & $past(pend_o)) == $past(pend_o)));

   // R9
   ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && (evt_i == '0)) |=> (pend_o == '0));

   // R9
   evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i != '0) |=> ((pend_o & $past(evt_i)) == $past(evt_i)));

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
   import gpio_irq_pkg::*;
#(
   parameter int N_PINS    = 32,
   parameter bit EXT_MODES = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_PINS-1:0] pin_i,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [N_PINS-1:0] wdata_i,
   output logic [N_PINS-1:0] rdata_o,
   output logic              irq_o
);

   if (N_PINS < 1) begin : g_bad_width
      $error("gpio_irq_ctrl: N_PINS must be at least 1");
   end

   localparam int NCFG = 4;
   localparam int CF_MASK = 0;
   localparam int CF_XM   = 1;
   localparam int CF_TYP  = 2;
   localparam int CF_POL  = 3;

   logic [NCFG-1:0]   set_s;
   logic [NCFG-1:0]   clr_s;
   logic [N_PINS-1:0] cfg_q [NCFG];
   logic [N_PINS-1:0] evt;
   logic [N_PINS-1:0] pend;
   logic              ack;

   always_comb begin
      set_s = '0;
      clr_s = '0;
      if (wr_i) begin
         set_s[CF_MASK] = (addr_i == A_MASK_SET);
         clr_s[CF_MASK] = (addr_i == A_MASK_CLR);
         set_s[CF_XM]   = (addr_i == A_XM_SET);
         clr_s[CF_XM]   = (addr_i == A_XM_CLR);
         set_s[CF_TYP]  = (addr_i == A_TYP_LEVEL);
         clr_s[CF_TYP]  = (addr_i == A_TYP_EDGE);
         set_s[CF_POL]  = (addr_i == A_POL_HIGH);
         clr_s[CF_POL]  = (addr_i == A_POL_LOW);
      end
   end

   for (genvar c = 0; c < NCFG; c++) begin : g_cfg
      gpio_irq_setclr #(.W(N_PINS)) u_reg (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_i   (set_s[c]),
         .clr_i   (clr_s[c]),
         .wdata_i (wdata_i),
         .q_o     (cfg_q[c])
      );
   end

   gpio_irq_detect #(.N_PINS(N_PINS), .EXT_MODES(EXT_MODES)) u_detect (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_i   (pin_i),
      .xmode_i (cfg_q[CF_XM]),
      .level_i (cfg_q[CF_TYP]),
      .high_i  (cfg_q[CF_POL]),
      .evt_o   (evt)
   );

   assign ack = rd_i && (addr_i == A_PEND);

   gpio_irq_pend #(.N_PINS(N_PINS)) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_i  (evt),
      .ack_i  (ack),
      .mask_i (cfg_q[CF_MASK]),
      .pend_o (pend),
      .irq_o  (irq_o)
   );

   always_comb begin
      rdata_o = '0;
      if (rd_i) begin
         case (addr_i)
            A_MASK_STAT: rdata_o = cfg_q[CF_MASK];
            A_XM_STAT:   rdata_o = cfg_q[CF_XM];
            A_TYP_STAT:  rdata_o = cfg_q[CF_TYP];
            A_POL_STAT:  rdata_o = cfg_q[CF_POL];
            A_PEND:      rdata_o = pend;
            default:     rdata_o = '0;
         endcase
      end
   end

   // R10
   irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q[CF_MASK] == '0) |-> !irq_o);

   // R11
   no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && (addr_i > A_PEND)) |=> $stable(cfg_q[CF_MASK]));

endmodule

// File: tb/gpio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb_top;

   localparam int N = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] pin = '0;
   logic         wr = 1'b0;
   logic         rd = 1'b0;
   logic [3:0]   addr = '0;
   logic [N-1:0] wdata = '0;
   logic [N-1:0] rdata;
   logic         irq;

   int n_checks = 0;
   int n_fail   = 0;
   int n_cyc    = 0;
   string cur_req = "R1";

   // reference model state
   bit [N-1:0] m_mask, m_xm, m_lvl, m_hi, m_pend, m_prev;

   always #4 clk = ~clk;

   gpio_irq_ctrl #(.N_PINS(N)) dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_i   (pin),
      .wr_i    (wr),
      .rd_i    (rd),
      .addr_i  (addr),
      .wdata_i (wdata),
      .rdata_o (rdata),
      .irq_o   (irq)
   );

   task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s (phase %s) at cycle %0d: got %h expected %h", req, cur_req, n_cyc, got, exp);
      end
   endtask

   function automatic string rd_req(input logic [3:0] a);
      case (a)
         4'd2:    return "R2";
         4'd5:    return "R4";
         4'd8:    return "R5";
         4'd11:   return "R6";
         4'd12:   return "R9";
         default: return "R11";
      endcase
   endfunction

   // compare one ns before each rising edge, then advance the model
   always @(negedge clk) begin
      #3;
      n_cyc++;
      if (!rst_n) begin
         check("R1", {31'b0, irq}, '0);
         m_mask = '0; m_xm = '0; m_lvl = '0; m_hi = '0; m_pend = '0;
         m_prev = pin;
      end else begin
         bit [N-1:0] e_rd;
         bit [N-1:0] evt;
         e_rd = '0;
         if (rd) begin
            case (addr)
               4'd2:  e_rd = m_mask;
               4'd5:  e_rd = m_xm;
               4'd8:  e_rd = m_lvl;
               4'd11: e_rd = m_hi;
               4'd12: e_rd = m_pend;
               default: e_rd = '0;
            endcase
         end
         check(rd ? rd_req(addr) : "R11", rdata, e_rd);
         check("R10", {31'b0, irq}, {31'b0, |(m_pend & m_mask)});
         for (int i = 0; i < N; i++) begin
            bit p, q;
            p = pin[i];
            q = m_prev[i];
            if (!m_xm[i])
               evt[i] = (p != q);
            else if (m_lvl[i])
               evt[i] = (p == m_hi[i]);
            else if (m_hi[i])
               evt[i] = p && !q;
            else
               evt[i] = !p && q;
         end
         if (rd && addr == 4'd12) m_pend = '0;
         m_pend = m_pend | evt;
         if (wr) begin
            case (addr)
               4'd0:  m_mask = m_mask | wdata;
               4'd1:  m_mask = m_mask & ~wdata;
               4'd3:  m_xm   = m_xm | wdata;
               4'd4:  m_xm   = m_xm & ~wdata;
               4'd6:  m_lvl  = m_lvl & ~wdata;
               4'd7:  m_lvl  = m_lvl | wdata;
               4'd9:  m_hi   = m_hi & ~wdata;
               4'd10: m_hi   = m_hi | wdata;
               default: ;
            endcase
         end
         m_prev = pin;
      end
   end

   task automatic step(input logic w, input logic r, input logic [3:0] a,
                       input logic [N-1:0] d, input logic [N-1:0] p);
      @(negedge clk);
      wr = w; rd = r; addr = a; wdata = d; pin = p;
   endtask

   task automatic wr_reg(input logic [3:0] a, input logic [N-1:0] d);
      step(1'b1, 1'b0, a, d, pin);
   endtask

   task automatic rd_reg(input logic [3:0] a);
      step(1'b0, 1'b1, a, '0, pin);
   endtask

   task automatic idle(input logic [N-1:0] p);
      step(1'b0, 1'b0, 4'd0, '0, p);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin : stim
      int unsigned lfsr;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset views
      cur_req = "R1";
      rd_reg(4'd2); rd_reg(4'd5); rd_reg(4'd8); rd_reg(4'd11); rd_reg(4'd12);
      // R2: mask set and clear
      cur_req = "R2";
      wr_reg(4'd0, 32'h0000_00FF); rd_reg(4'd2);
      wr_reg(4'd1, 32'h0000_000F); rd_reg(4'd2);
      wr_reg(4'd0, 32'h0000_000F);
      // R3: both-edge detection, rise then fall
      cur_req = "R3";
      idle(32'h0000_0001); idle(32'h0000_0001); rd_reg(4'd12);
      idle(32'h0000_0000); rd_reg(4'd12); idle(pin);
      // R10: pending without mask enable
      cur_req = "R10";
      idle(32'h0001_0000); idle(pin); rd_reg(4'd12);
      // R9: edge in the same cycle as the status read is kept
      cur_req = "R9";
      idle(32'h0000_0004);
      step(1'b0, 1'b1, 4'd12, '0, 32'h0000_0006);
      rd_reg(4'd12); rd_reg(4'd12);
      // R4 R5 R6: extended mode configuration
      cur_req = "R4";
      wr_reg(4'd3, 32'h0000_00F0); rd_reg(4'd5);
      cur_req = "R5";
      wr_reg(4'd7, 32'h0000_00A0); wr_reg(4'd6, 32'h0000_0080); rd_reg(4'd8);
      wr_reg(4'd7, 32'h0000_0080); rd_reg(4'd8);
      cur_req = "R6";
      wr_reg(4'd10, 32'h0000_0030); wr_reg(4'd9, 32'h0000_0010); rd_reg(4'd11);
      rd_reg(4'd12); rd_reg(4'd12);
      // R7: pin4 edge/low (falling only), pin6 edge/low; make pin4 rising-only
      cur_req = "R7";
      wr_reg(4'd10, 32'h0000_0010); wr_reg(4'd9, 32'h0000_0040);
      rd_reg(4'd12);
      idle(pin | 32'h0000_0050); rd_reg(4'd12);
      idle(pin & ~32'h0000_0050); rd_reg(4'd12); rd_reg(4'd12);
      // R8: pin5 level-high, pin7 level-low
      cur_req = "R8";
      idle(pin | 32'h0000_0020); rd_reg(4'd12); rd_reg(4'd12);
      idle(pin & ~32'h0000_0020); rd_reg(4'd12); rd_reg(4'd12);
      idle(pin | 32'h0000_0080); rd_reg(4'd12); rd_reg(4'd12);
      // R4: leaving extended mode restores both edges
      cur_req = "R4";
      wr_reg(4'd4, 32'h0000_00F0); rd_reg(4'd5);
      idle(pin | 32'h0000_0010); idle(pin & ~32'h0000_0010); rd_reg(4'd12);
      // R11: stray writes and reads of write-only addresses
      cur_req = "R11";
      wr_reg(4'd2, '1); wr_reg(4'd12, '1); wr_reg(4'd15, '1); wr_reg(4'd8, '1);
      rd_reg(4'd2); rd_reg(4'd8); rd_reg(4'd0); rd_reg(4'd7); rd_reg(4'd14);
      // mixed traffic
      cur_req = "R3";
      wr_reg(4'd0, '1);
      wr_reg(4'd3, 32'hF0F0_0000); wr_reg(4'd7, 32'hFF00_0000); wr_reg(4'd10, 32'hCC00_CC00);
      lfsr = 32'h1234_5678;
      for (int k = 0; k < 300; k++) begin
         lfsr = lfsr ^ (lfsr << 13);
         lfsr = lfsr ^ (lfsr >> 17);
         lfsr = lfsr ^ (lfsr << 5);
         if (lfsr[3:0] == 4'h0) rd_reg(4'd12);
         else idle(pin ^ (lfsr & 32'h8421_1248));
      end
      // R2: all ones to the clear address masks every pin
      cur_req = "R2";
      idle(pin ^ 32'h0000_0100);
      wr_reg(4'd1, '1); rd_reg(4'd2); idle(pin); idle(pin);
      @(negedge clk);
      #5;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule